// File: doc/BRIEF.md
# Superpixel Hit Cluster Packer

This block sits inside the pixel matrix and serves one 4x4 group of pixels. Each cycle it looks at the sixteen pixel hit registers of the group. Each register holds a valid flag, a 4-bit time-over-threshold (ToT) value and a 12-bit bunch identifier. The block merges every pending hit that shares one bunch identifier into a single packet. The group address and the bunch identifier are stored once in that packet, so a pixel hit no longer needs its own 32-bit word (ToT, bunch, full pixel address) on the column bus.

A packet carries four things: the 12-bit group address, the bunch identifier, a 16-bit hit map, and the ToT values of the hit pixels only, in compacted form. Readout is sparse: an idle group sends nothing. When the pending hits belong to several bunches, the oldest bunch goes out first and the other hits wait. Packets leave on a valid/ready stream. When a packet is accepted, the block sends one clear pulse to each pixel it contained.

Top module: `spx_cluster_packer`

## Requirements
- R1: While reset is held and in the first cycle after it, `pkt_valid` is low and `hit_clr` is all zero.
- R2: When no pixel valid flag is set, `pkt_valid` stays low.
- R3: A packet presents `pkt_addr` equal to `spx_addr`, the shared bunch identifier on `pkt_bid`, and a hit map in which bit i stands for pixel i (row-major index, row*4+column).
- R4: ToT values are compacted in ascending pixel order. Slot k occupies `pkt_tot[4k+3:4k]`, and slots beyond the hit count are zero. `pkt_cnt` equals the number of set map bits.
- R5: All pending hits whose bunch identifier equals the selected one go into the same packet.
- R6: The selected bunch is the pending one with the largest age, where age is (`bid_now` − bid) modulo 4096. Hits with other bunch identifiers stay pending.
- R7: `hit_clr` equals the packet's hit map in a cycle where `pkt_valid` and `pkt_ready` are both high. It is zero in every other cycle.
- R8: While `pkt_valid` is high and `pkt_ready` is low, the packet fields do not change. Hits that arrive during that time are not added.
- R9: A packet from the remaining hits becomes valid in the cycle right after an acceptance, with no idle gap. A pending hit produces a packet one cycle after it appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spx_addr | input | 12 | Address of this 4x4 group |
| bid_now | input | 12 | Current bunch counter, used to compute hit age |
| hit_vld | input | 16 | Valid flag of each pixel hit register |
| hit_tot | input | 64 | ToT of pixel i at bits [4i+3:4i] |
| hit_bid | input | 192 | Bunch identifier of pixel i at bits [12i+11:12i] |
| hit_clr | output | 16 | Clear pulse for each pixel in an accepted packet |
| pkt_valid | output | 1 | Packet present |
| pkt_ready | input | 1 | Downstream accepts the packet |
| pkt_addr | output | 12 | Group address |
| pkt_bid | output | 12 | Shared bunch identifier |
| pkt_map | output | 16 | Hit map |
| pkt_cnt | output | 5 | Number of ToT slots in use |
| pkt_tot | output | 64 | Compacted ToT slots |

## Verification
The vector table covers five hit patterns:
- a lone pixel, which shows the map and slot 0 placement;
- the full group, which exercises all sixteen slots;
- two interleaved bunch groups, where the numerically smaller identifier is also the older one;
- a pair of bunches that straddle the 4096 wrap, where the numerically larger identifier is the older one and only modulo arithmetic picks it;
- a case where the current bunch has age zero and must lose to an older group.

For each pattern the bench first holds `pkt_ready` low, which separates a held packet from one that is rebuilt. It then checks the clear pulse in the accept cycle and the back-to-back follow-up packet.

// File: rtl/spx_cluster_packer.sv
module spx_cluster_packer #(
  parameter int NPIX   = 16,
  parameter int TOT_W  = 4,
  parameter int BID_W  = 12,
  parameter int ADDR_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      spx_addr,
  input  logic [BID_W-1:0]       bid_now,
  input  logic [NPIX-1:0]        hit_vld,
  input  logic [NPIX*TOT_W-1:0]  hit_tot,
  input  logic [NPIX*BID_W-1:0]  hit_bid,
  output logic [NPIX-1:0]        hit_clr,
  output logic                   pkt_valid,
  input  logic                   pkt_ready,
  output logic [ADDR_W-1:0]      pkt_addr,
  output logic [BID_W-1:0]       pkt_bid,
  output logic [NPIX-1:0]        pkt_map,
  output logic [$clog2(NPIX+1)-1:0] pkt_cnt,
  output logic [NPIX*TOT_W-1:0]  pkt_tot
);
  localparam int CNT_W = $clog2(NPIX+1);

  logic              accept, load;
  logic [NPIX-1:0]   cand, sel_map;
  logic [BID_W-1:0]  best_bid, best_age, age;
  logic              found;
  logic [CNT_W-1:0]  sel_cnt;
  logic [NPIX*TOT_W-1:0] sel_tot;

  assign accept  = pkt_valid & pkt_ready;
  assign load    = ~pkt_valid | pkt_ready;
  assign hit_clr = accept ? pkt_map : '0;
  assign cand    = hit_vld & ~hit_clr;

  always_comb begin
    found    = 1'b0;
    best_bid = '0;
    best_age = '0;
    age      = '0;
    for (int i = 0; i < NPIX; i++) begin
      age = bid_now - hit_bid[i*BID_W +: BID_W];
      if (cand[i] && (!found || age > best_age)) begin
        found    = 1'b1;
        best_age = age;
        best_bid = hit_bid[i*BID_W +: BID_W];
      end
    end
    for (int i = 0; i < NPIX; i++)
      sel_map[i] = cand[i] && (hit_bid[i*BID_W +: BID_W] == best_bid);
  end

  always_comb begin
    sel_tot = '0;
    sel_cnt = '0;
    for (int i = 0; i < NPIX; i++) begin
      if (sel_map[i]) begin
        sel_tot[int'(sel_cnt)*TOT_W +: TOT_W] = hit_tot[i*TOT_W +: TOT_W];
        sel_cnt = sel_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_valid <= 1'b0;
      pkt_addr  <= '0;
      pkt_bid   <= '0;
      pkt_map   <= '0;
      pkt_cnt   <= '0;
      pkt_tot   <= '0;
    end else if (load) begin
      pkt_valid <= found;
      pkt_addr  <= spx_addr;
      pkt_bid   <= best_bid;
      pkt_map   <= sel_map;
      pkt_cnt   <= sel_cnt;
      pkt_tot   <= sel_tot;
    end
  end

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_map) && $stable(pkt_bid)
                                && $stable(pkt_tot) && $stable(pkt_addr));

  a_r3_map_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> pkt_map != '0);

  a_r4_count_matches_map: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> int'(pkt_cnt) == $countones(pkt_map));

  a_r7_clear_only_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_clr & ~hit_vld) == '0);

  a_r9_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && pkt_ready && ((hit_vld & ~pkt_map) != '0) |=> pkt_valid);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid && hit_vld == '0 |=> !pkt_valid);
endmodule

// File: tb/tb_spx_cluster_packer.sv
module tb_spx_cluster_packer;
  logic clk = 0, rst_n = 0;
  logic [11:0]  spx_addr = 0, bid_now = 0;
  logic [15:0]  hit_vld = 0;
  logic [63:0]  hit_tot = 0;
  logic [191:0] hit_bid = 0;
  logic [15:0]  hit_clr;
  logic pkt_valid, pkt_ready = 0;
  logic [11:0] pkt_addr, pkt_bid;
  logic [15:0] pkt_map;
  logic [4:0]  pkt_cnt;
  logic [63:0] pkt_tot;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spx_cluster_packer dut (.*);

  // pixel hit register model: cleared by the packer's pulse
  always @(posedge clk) hit_vld <= hit_vld & ~hit_clr;

  // vld, bid-B mask, bidA, bidB, now, exp map1, exp bid1, exp bid2
  localparam logic [15:0] VLD [5] = '{16'h0001, 16'hFFFF, 16'h8421, 16'h00F0, 16'hA5A5};
  localparam logic [15:0] BM  [5] = '{16'h0000, 16'h0000, 16'h8400, 16'h0030, 16'h00FF};
  localparam logic [11:0] BA  [5] = '{12'h010, 12'h123, 12'h100, 12'h002, 12'h500};
  localparam logic [11:0] BB  [5] = '{12'h000, 12'h000, 12'h0F0, 12'hFFE, 12'h400};
  localparam logic [11:0] NOW [5] = '{12'h020, 12'h200, 12'h180, 12'h004, 12'h500};
  localparam logic [15:0] EM1 [5] = '{16'h0001, 16'hFFFF, 16'h8400, 16'h0030, 16'h00A5};
  localparam logic [11:0] EB1 [5] = '{12'h010, 12'h123, 12'h0F0, 12'hFFE, 12'h400};
  localparam logic [11:0] EB2 [5] = '{12'h000, 12'h000, 12'h100, 12'h002, 12'h500};

  function automatic logic [63:0] exp_tot(input logic [15:0] m, input int base);
    logic [63:0] r = '0; int k = 0;
    for (int i = 0; i < 16; i++)
      if (m[i]) begin r[k*4 +: 4] = 4'((i + base) & 15); k++; end
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_pkt(input string req, input logic [15:0] m, input logic [11:0] b, input int base);
    chk({req, " valid"}, 64'(pkt_valid), 64'(m != 0));
    if (m != 0) begin
      chk({req, " R3 addr"}, 64'(pkt_addr), 64'(spx_addr));
      chk({req, " R3 bid"},  64'(pkt_bid),  64'(b));
      chk({req, " R5 map"},  64'(pkt_map),  64'(m));
      chk({req, " R4 tot"},  pkt_tot,       exp_tot(m, base));
      chk({req, " R4 cnt"},  64'(pkt_cnt),  64'($countones(m)));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    hit_vld = 16'h0003;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", 64'(pkt_valid), 0);
    chk("R1 reset clr",   64'(hit_clr),   0);
    hit_vld = 0;
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset valid", 64'(pkt_valid), 0);
    repeat (4) @(negedge clk);
    chk("R2 idle no packet", 64'(pkt_valid), 0);

    for (int v = 0; v < 5; v++) begin
      logic [15:0] m2;
      spx_addr = 12'h3A0 + 12'(v);
      bid_now  = NOW[v];
      for (int i = 0; i < 16; i++) begin
        hit_tot[i*4 +: 4]   = 4'((i + v) & 15);
        hit_bid[i*12 +: 12] = BM[v][i] ? BB[v] : BA[v];
      end
      hit_vld = VLD[v];
      @(negedge clk);
      chk_pkt($sformatf("R6 vec%0d first", v), EM1[v], EB1[v], v);
      chk("R7 no clr while stalled", 64'(hit_clr), 0);
      hit_vld = hit_vld | 16'h0;
      @(negedge clk);
      chk_pkt($sformatf("R8 vec%0d held", v), EM1[v], EB1[v], v);
      pkt_ready = 1;
      #1;
      chk("R7 clr equals map", 64'(hit_clr), 64'(EM1[v]));
      @(negedge clk);
      m2 = VLD[v] & ~EM1[v];
      chk_pkt($sformatf("R9 vec%0d second", v), m2, EB2[v], v);
      @(negedge clk);
      pkt_ready = 0;
      chk("R2 drained", 64'(pkt_valid), 0);
      chk("R7 pixels cleared", 64'(hit_vld), 0);
    end

    // R8: a hit arriving during a stall with the same bunch is not merged
    bid_now = 12'h050;
    for (int i = 0; i < 16; i++) begin
      hit_bid[i*12 +: 12] = 12'h040;
      hit_tot[i*4 +: 4]   = 4'(i);
    end
    hit_vld = 16'h0002;
    @(negedge clk);
    hit_vld = hit_vld | 16'h0100;
    @(negedge clk);
    chk("R8 late hit not added", 64'(pkt_map), 64'h0002);
    pkt_ready = 1;
    @(negedge clk);
    chk("R9 late hit follows", 64'(pkt_map), 64'h0100);
    chk("R4 late hit tot slot0", pkt_tot, 64'h8);
    @(negedge clk);
    chk("R2 empty after drain", 64'(pkt_valid), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule